// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block holds a small set of programmable outbound windows and uses them to turn a local bus address into an address on the serial link side. Each window carries an enable, a type (configuration, I/O or memory), a 64-bit size mask, a 64-bit local base and a 64-bit remote base. A lookup presents one address. The bank compares it against every enabled window in parallel. One cycle later it returns either a hit, with the winning window index, its type, the translated address and, for configuration windows, the bus/device/function routing fields, or a miss.

The size mask is the bitwise complement of (window size − 1). Its low word lives in the upper bits of a window's control register, so the smallest window is 1 KB. The high word has its own register. A write-only register port programs the windows one 32-bit word at a time. The parameter `ACTIVE_WIN` sets how many windows are built. Writes aimed at higher indices are dropped.

Top module: `obw_xlate`

## Requirements
- R1: After reset every window is disabled, `rsp_valid`, `rsp_hit` and `rsp_miss` are low, and a lookup returns a miss.
- R2: A lookup with `lk_valid` high in one cycle produces `rsp_valid` high in exactly the next cycle. No response appears without a lookup.
- R3: A window hits when its enable (control bit 0) is set and (addr & mask) equals (local base & mask). The 64-bit mask is {upper-mask register, control bits 31:10, ten zero bits}. A disabled window never hits.
- R4: On a hit, `rsp_addr` is remote base | (addr & ~mask).
- R5: `rsp_type` returns control bits 2:1 of the winning window. The encodings are 0 configuration, 1 I/O and 2 memory.
- R6: When several windows hit, the lowest-numbered window wins.
- R7: On a miss `rsp_miss` is high, `rsp_hit` is low, and `rsp_win`, `rsp_type`, `rsp_addr` and the routing fields are zero.
- R8: A write whose window index is at or above `ACTIVE_WIN` changes nothing, and such an index never appears as a hit.
- R9: For a configuration-type hit, `rsp_bus`, `rsp_dev` and `rsp_fn` are remote-base bits 31:24, 23:19 and 18:16. For any other type they are zero.
- R10: The upper mask register takes part in matching, so windows larger than 4 GB compare and translate the address bits above bit 31 correctly.
- R11: `cfg_sel` selects the target register: 0 control, 1 upper mask, 2 local base low (bits 1:0 stored as zero), 3 local base high, 4 remote base low, 5 remote base high. A write is visible to a lookup issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | IW | Window index of the write |
| cfg_sel | input | 3 | Register select within the window |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Local address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Some window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_win | output | IW | Index of the winning window |
| rsp_type | output | 2 | Type of the winning window |
| rsp_addr | output | 64 | Translated link address |
| rsp_bus | output | 8 | Bus number (configuration hits) |
| rsp_dev | output | 5 | Device number (configuration hits) |
| rsp_fn | output | 3 | Function number (configuration hits) |

## Verification
The hardest situations to reach from the ports are overlapping windows, where the priority order decides the result, and windows whose size reaches into the upper mask word. The stimulus programs a memory window and an I/O window over the same region. It toggles the lower window's enable, so each lookup to that region resolves to a different owner. It also programs a 64 GB window through the upper mask register. Writes to unbuilt window indices are followed by lookups into the region those writes would have claimed, so any leak shows up as a hit.

// File: rtl/obw_pkg.sv
package obw_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned GRAN_LSB = 10;
  localparam int unsigned MLO_W    = WORD_W - GRAN_LSB;
  localparam int unsigned BDF_W    = 16;

  typedef enum logic [1:0] {
    WT_CFG  = 2'd0,
    WT_IO   = 2'd1,
    WT_MEM  = 2'd2,
    WT_RSVD = 2'd3
  } win_type_e;

  typedef enum logic [2:0] {
    RS_CTRL     = 3'd0,
    RS_MASK_HI  = 3'd1,
    RS_LBASE_LO = 3'd2,
    RS_LBASE_HI = 3'd3,
    RS_RBASE_LO = 3'd4,
    RS_RBASE_HI = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/obw_regfile.sv
module obw_regfile
  import obw_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int ACTIVE_WIN = 6,
  localparam int IW        = $clog2(NUM_WIN)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [IW-1:0]                    cfg_win,
  input  logic [2:0]                       cfg_sel,
  input  logic [WORD_W-1:0]                cfg_wdata,
  output logic [NUM_WIN-1:0]               win_en,
  output logic [NUM_WIN-1:0][1:0]          win_type,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_mask,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_lbase,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_rbase
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    if (g < ACTIVE_WIN) begin : g_live
      logic              en_q;
      logic [1:0]        type_q;
      logic [MLO_W-1:0]  mlo_q;
      logic [WORD_W-1:0] mhi_q;
      logic [ADDR_W-1:0] lb_q;
      logic [ADDR_W-1:0] rb_q;
      logic              sel_me;

      assign sel_me = cfg_we && (cfg_win == IW'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q   <= 1'b0;
          type_q <= 2'd0;
          mlo_q  <= '0;
          mhi_q  <= '0;
          lb_q   <= '0;
          rb_q   <= '0;
        end else if (sel_me) begin
          case (reg_sel_e'(cfg_sel))
            RS_CTRL: begin
              en_q   <= cfg_wdata[0];
              type_q <= cfg_wdata[2:1];
              mlo_q  <= cfg_wdata[WORD_W-1:GRAN_LSB];
            end
            RS_MASK_HI:  mhi_q              <= cfg_wdata;
            RS_LBASE_LO: lb_q[WORD_W-1:0]   <= {cfg_wdata[WORD_W-1:2], 2'b00};
            RS_LBASE_HI: lb_q[ADDR_W-1:WORD_W] <= cfg_wdata;
            RS_RBASE_LO: rb_q[WORD_W-1:0]   <= cfg_wdata;
            RS_RBASE_HI: rb_q[ADDR_W-1:WORD_W] <= cfg_wdata;
            default: ;
          endcase
        end
      end

      assign win_en[g]    = en_q;
      assign win_type[g]  = type_q;
      assign win_mask[g]  = {mhi_q, mlo_q, {GRAN_LSB{1'b0}}};
      assign win_lbase[g] = lb_q;
      assign win_rbase[g] = rb_q;
    end else begin : g_absent
      assign win_en[g]    = 1'b0;
      assign win_type[g]  = 2'd0;
      assign win_mask[g]  = '0;
      assign win_lbase[g] = '0;
      assign win_rbase[g] = '0;
    end
  end
endmodule

// File: rtl/obw_match.sv
module obw_match
  import obw_pkg::*;
#(
  parameter int NUM_WIN = 8
) (
  input  logic [ADDR_W-1:0]                lk_addr,
  input  logic [NUM_WIN-1:0]               win_en,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_mask,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_lbase,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_rbase,
  output logic [NUM_WIN-1:0]               hit_vec,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   xlat
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign hit_vec[g] = win_en[g] &&
                        ((lk_addr & win_mask[g]) == (win_lbase[g] & win_mask[g]));
    assign xlat[g]    = win_rbase[g] | (lk_addr & ~win_mask[g]);
  end
endmodule

// File: rtl/obw_pick.sv
module obw_pick
  import obw_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IW     = $clog2(NUM_WIN)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             lk_valid,
  input  logic [NUM_WIN-1:0]               hit_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]   xlat,
  input  logic [NUM_WIN-1:0][1:0]          win_type,
  input  logic [NUM_WIN-1:0][BDF_W-1:0]    win_bdf,
  output logic                             rsp_valid,
  output logic                             rsp_hit,
  output logic                             rsp_miss,
  output logic [IW-1:0]                    rsp_win,
  output logic [1:0]                       rsp_type,
  output logic [ADDR_W-1:0]                rsp_addr,
  output logic [7:0]                       rsp_bus,
  output logic [4:0]                       rsp_dev,
  output logic [2:0]                       rsp_fn
);
  logic          found;
  logic [IW-1:0] sel;
  logic          take;
  logic          is_cfg;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  assign take   = lk_valid && found;
  assign is_cfg = take && (win_type_e'(win_type[sel]) == WT_CFG);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_type  <= 2'd0;
      rsp_addr  <= '0;
      rsp_bus   <= '0;
      rsp_dev   <= '0;
      rsp_fn    <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= take;
      rsp_miss  <= lk_valid && !found;
      rsp_win   <= take ? sel : '0;
      rsp_type  <= take ? win_type[sel] : 2'd0;
      rsp_addr  <= take ? xlat[sel] : '0;
      rsp_bus   <= is_cfg ? win_bdf[sel][15:8] : '0;
      rsp_dev   <= is_cfg ? win_bdf[sel][7:3]  : '0;
      rsp_fn    <= is_cfg ? win_bdf[sel][2:0]  : '0;
    end
  end
endmodule

// File: rtl/obw_xlate.sv
module obw_xlate
  import obw_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int ACTIVE_WIN = 6,
  localparam int IW        = $clog2(NUM_WIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [IW-1:0]       cfg_win,
  input  logic [2:0]          cfg_sel,
  input  logic [WORD_W-1:0]   cfg_wdata,
  input  logic                lk_valid,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [IW-1:0]       rsp_win,
  output logic [1:0]          rsp_type,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic [7:0]          rsp_bus,
  output logic [4:0]          rsp_dev,
  output logic [2:0]          rsp_fn
);
  logic [NUM_WIN-1:0]               win_en;
  logic [NUM_WIN-1:0][1:0]          win_type;
  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_mask;
  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_lbase;
  logic [NUM_WIN-1:0][ADDR_W-1:0]   win_rbase;
  logic [NUM_WIN-1:0][BDF_W-1:0]    win_bdf;
  logic [NUM_WIN-1:0]               hit_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0]   xlat;

  obw_regfile #(.NUM_WIN(NUM_WIN), .ACTIVE_WIN(ACTIVE_WIN)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .win_en(win_en),
    .win_type(win_type), .win_mask(win_mask), .win_lbase(win_lbase),
    .win_rbase(win_rbase)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_bdf
    assign win_bdf[g] = win_rbase[g][WORD_W-1:WORD_W-BDF_W];
  end

  obw_match #(.NUM_WIN(NUM_WIN)) u_match (
    .lk_addr(lk_addr), .win_en(win_en), .win_mask(win_mask),
    .win_lbase(win_lbase), .win_rbase(win_rbase),
    .hit_vec(hit_vec), .xlat(xlat)
  );

  obw_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .hit_vec(hit_vec),
    .xlat(xlat), .win_type(win_type), .win_bdf(win_bdf),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_win(rsp_win), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
    .rsp_bus(rsp_bus), .rsp_dev(rsp_dev), .rsp_fn(rsp_fn)
  );
endmodule

// File: rtl/obw_xlate_chk.sv
module obw_xlate_chk #(
  parameter int NUM_WIN    = 8,
  parameter int ACTIVE_WIN = 6,
  localparam int IW        = $clog2(NUM_WIN)
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_miss,
  input logic [IW-1:0] rsp_win,
  input logic [1:0]    rsp_type,
  input logic [63:0]   rsp_addr,
  input logic [7:0]    rsp_bus,
  input logic [4:0]    rsp_dev,
  input logic [2:0]    rsp_fn
);
  a_r2_response_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  a_r7_single_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss));

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss));

  a_r7_miss_zeroed: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_addr == 64'd0 && rsp_win == '0 && rsp_type == 2'd0));

  a_r9_routing_cfg_only: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit && rsp_type != 2'd0) |-> ({rsp_bus, rsp_dev, rsp_fn} == 16'd0));

  a_r8_absent_never_wins: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (int'(rsp_win) < ACTIVE_WIN));
endmodule

bind obw_xlate obw_xlate_chk #(.NUM_WIN(NUM_WIN), .ACTIVE_WIN(ACTIVE_WIN)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win),
  .rsp_type(rsp_type), .rsp_addr(rsp_addr), .rsp_bus(rsp_bus),
  .rsp_dev(rsp_dev), .rsp_fn(rsp_fn)
);

// File: tb/obw_xlate_tb_top.sv
module obw_xlate_tb_top;
  localparam int NW  = 8;
  localparam int ACT = 6;
  localparam int IW  = 3;

  typedef struct packed {
    logic        hit;
    logic        miss;
    logic [2:0]  win;
    logic [1:0]  typ;
    logic [63:0] addr;
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [2:0]  fn;
  } resp_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        cfg_we;
  logic [IW-1:0] cfg_win;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        lk_valid;
  logic [63:0] lk_addr;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [IW-1:0] rsp_win;
  logic [1:0]  rsp_type;
  logic [63:0] rsp_addr;
  logic [7:0]  rsp_bus;
  logic [4:0]  rsp_dev;
  logic [2:0]  rsp_fn;

  obw_xlate #(.NUM_WIN(NW), .ACTIVE_WIN(ACT)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_win(rsp_win), .rsp_type(rsp_type),
    .rsp_addr(rsp_addr), .rsp_bus(rsp_bus), .rsp_dev(rsp_dev),
    .rsp_fn(rsp_fn)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] m_reg [NW][6];
  resp_t exp_q[$];
  string tag_q[$];

  task automatic check(bit ok, string tag, string act, string expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, expv);
    end
  endtask

  function automatic resp_t predict(logic [63:0] a);
    resp_t r = '0;
    for (int w = NW - 1; w >= 0; w--) begin
      logic [63:0] mk, lb, rb;
      mk = {m_reg[w][1], m_reg[w][0][31:10], 10'b0};
      lb = {m_reg[w][3], m_reg[w][2][31:2], 2'b00};
      rb = {m_reg[w][5], m_reg[w][4]};
      if (m_reg[w][0][0] && ((a & mk) == (lb & mk))) begin
        r.hit  = 1'b1;
        r.win  = 3'(w);
        r.typ  = m_reg[w][0][2:1];
        r.addr = rb | (a & ~mk);
        if (m_reg[w][0][2:1] == 2'd0) begin
          r.bus = rb[31:24]; r.dev = rb[23:19]; r.fn = rb[18:16];
        end else begin
          r.bus = '0; r.dev = '0; r.fn = '0;
        end
      end
    end
    r.miss = !r.hit;
    return r;
  endfunction

  task automatic wr(int w, int s, logic [31:0] d);
    @(negedge clk);
    lk_valid = 1'b0; cfg_we = 1'b1;
    cfg_win = 3'(w); cfg_sel = 3'(s); cfg_wdata = d;
    if (w < ACT) m_reg[w][s] = d;
  endtask

  task automatic setwin(int w, logic [31:0] c, logic [31:0] mh, logic [31:0] ll,
                        logic [31:0] lh, logic [31:0] rl, logic [31:0] rh);
    wr(w, 0, c); wr(w, 1, mh); wr(w, 2, ll);
    wr(w, 3, lh); wr(w, 4, rl); wr(w, 5, rh);
  endtask

  task automatic look(logic [63:0] a, string tag);
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b1; lk_addr = a;
    exp_q.push_back(predict(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      cfg_we = 1'b0; lk_valid = 1'b0;
    end
  endtask

  // monitor: compares each response against the scoreboard head
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", "rsp_valid=1", "no response");
      end else begin
        resp_t e, g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = '{rsp_hit, rsp_miss, rsp_win, rsp_type, rsp_addr, rsp_bus, rsp_dev, rsp_fn};
        check(g == e, t, $sformatf("%h", g), $sformatf("%h", e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 6; s++) m_reg[w][s] = '0;
    rst = 1'b1; cfg_we = 1'b0; cfg_win = '0; cfg_sel = '0;
    cfg_wdata = '0; lk_valid = 1'b0; lk_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(!rsp_valid && !rsp_hit && !rsp_miss, "R1 reset outputs",
          $sformatf("%b%b%b", rsp_valid, rsp_hit, rsp_miss), "000");
    look(64'h0000_0000_4000_0000, "R1 lookup after reset misses");
    look(64'h0000_0000_0000_0000, "R7 miss fields zero");

    // window 0: configuration, 1 MB; low base bits written as 3 (R11)
    setwin(0, 32'hFFF0_0001, 32'hFFFF_FFFF, 32'h4000_0003, 32'h0, 32'h122B_0000, 32'h0);
    look(64'h0000_0000_4001_2345, "R9 config routing fields");
    look(64'h0000_0000_400F_FFFF, "R3 last address inside window");
    look(64'h0000_0000_4010_0000, "R3 first address past window");
    look(64'h0000_0000_3FFF_FFFF, "R3 address below window");

    // window 1: memory, 64 KB
    setwin(1, 32'hFFFF_0005, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 32'hC000_0000, 32'hAB);
    look(64'h0000_0001_8000_BEEF, "R4 memory translation");
    look(64'h0000_0000_8000_BEEF, "R10 upper bits must match");

    // window 2: I/O, 4 KB overlapping window 1, left disabled
    setwin(2, 32'hFFFF_F002, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1, 32'h5555_0000, 32'h0);
    look(64'h0000_0001_8000_0010, "R3 disabled window ignored");
    wr(2, 0, 32'hFFFF_F003);
    look(64'h0000_0001_8000_0010, "R6 lower index wins overlap");
    wr(1, 0, 32'hFFFF_0004);
    look(64'h0000_0001_8000_0010, "R5 I/O type from next window");
    look(64'h0000_0001_8000_1010, "R3 outside small window");
    wr(1, 0, 32'hFFFF_0005);
    look(64'h0000_0001_8000_0020, "R6 re-enabled lower window wins");

    // window 3: memory, 64 GB via upper mask
    setwin(3, 32'h0000_0005, 32'hFFFF_FFF0, 32'h0, 32'h20, 32'h0, 32'h900);
    look(64'h0000_002F_1234_5678, "R10 large window translation");
    look(64'h0000_0030_0000_0000, "R10 past large window");

    // window 4: second configuration window
    setwin(4, 32'hFFFF_FC01, 32'hFFFF_FFFF, 32'h6000_0000, 32'h0, 32'hA552_0000, 32'h0);
    look(64'h0000_0000_6000_03FC, "R9 config fields second window");

    // absent windows 6 and 7: writes dropped
    setwin(6, 32'hFFF0_0005, 32'hFFFF_FFFF, 32'h7000_0000, 32'h0, 32'h1234_0000, 32'h0);
    setwin(7, 32'hFFF0_0001, 32'hFFFF_FFFF, 32'h7000_0000, 32'h0, 32'h1234_0000, 32'h0);
    look(64'h0000_0000_7000_0100, "R8 write to absent index ignored");
    idle(2);
    check(!rsp_valid, "R2 idle gives no response", $sformatf("%b", rsp_valid), "0");

    // R11: write then lookup in the next cycle
    wr(0, 0, 32'hFFF0_0000);
    look(64'h0000_0000_4001_2345, "R11 disable visible next cycle");
    wr(5, 0, 32'hFFF0_0005);
    look(64'h0000_0000_0000_0040, "R11 window 5 at base zero");
    look(64'h0000_0001_8000_FFFF, "R2 back-to-back lookup");
    idle(3);
    check(exp_q.size() == 0, "R2 every lookup answered",
          $sformatf("%0d pending", exp_q.size()), "0 pending");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule